// File: doc/BRIEF.md
# Power-Management Function Configuration Decoder

This block holds the configuration bytes of a power-management function and turns them into two I/O address decoders. Each of two relocatable windows has a 64-byte-aligned base and an enable bit in a separate control byte. The first is a 64-byte power-management window and the second a system-management-bus window. Software programs the bytes through a dword-addressed, byte-enabled configuration port. The block compares every I/O address on `io_addr` against both windows and raises `pm_hit` or `smb_hit`.

A window's base and enable are copied into a decode latch only when a configuration write lands on that window's base dword or on its enable byte. The copy happens one clock after the write. Writes elsewhere never reach the decoders. A few header bytes are constants. One general scratch dword is cleared at reset.

Top module: `pmcfg_decoder`

## Requirements
- R1: After reset, dword 0x10 (bytes 0x40–0x43) reads 0x00000001, dword 0x20 (byte 0x80 in bits 7:0) reads 0, and `pm_hit` is low for every I/O address.
- R2: After reset, dword 0x24 (bytes 0x90–0x93) reads `SMB_RST_BASE & 0xFFC0 | 1`, dword 0x34 reads 0x00090000 (byte 0xD2 in bits 23:16 = 0x09), and `smb_hit` is high for addresses inside the reset window.
- R3: Dword 0x01 reads 0x02800000 (byte 0x06 = 0x80, byte 0x07 = 0x02), dword 0x0F reads 0x00000100 (byte 0x3D = 1), and writes to them leave those values unchanged.
- R4: A write changes only the bytes whose `cfg_be` bit is set. In both base dwords, only bits 15:6 are writable, bit 0 always reads 1, and all other bits read 0.
- R5: `pm_hit` is high exactly when bit 0 of byte 0x80 is set and `io_addr[15:6]` equals bits 15:6 of the power-management base.
- R6: `smb_hit` is high exactly when bit 0 of byte 0xD2 is set and `io_addr[15:6]` equals bits 15:6 of the bus base.
- R7: A write is visible on `cfg_rdata` after the clock edge that samples it. The hit outputs reflect the write only after the following edge.
- R8: Writes to other dwords, or to bytes of the enable dwords other than bytes 0x80 and 0xD2, do not change either decode.
- R9: Dword 0x16 (bytes 0x58–0x5B) is fully writable per byte and reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables, bit n selects byte n of the dword |
| cfg_wdata | input | 32 | Write data, little-endian bytes |
| cfg_rdata | output | 32 | Combinational read data for `cfg_dw` |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the enabled power-management window |
| smb_hit | output | 1 | Address falls in the enabled bus window |

## Verification
A wrong base or enable inside a decode latch appears as a hit on the wrong 64-byte block, or as a missing hit. Sweeping all 1024 blocks exposes this one clock after the latch copy. The bench checks, for several bases, that the hit asserts on exactly one block. A stale or early latch copy shows up as a hit that changes one edge too early or too late after a write, so the bench samples both edges. A corrupted read-only bit is visible on the very next read of the base dword.

// File: rtl/pmcfg_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the configuration decoder.
// Assumes a 256-byte configuration space addressed as 64 dwords.
package pmcfg_pkg;
    localparam int CFG_DW_W = 6;

    // Dword indices (byte offset / 4); the decoders depend on these.
    localparam logic [CFG_DW_W-1:0] DW_HDR_STS  = 6'h01; // bytes 0x04-0x07
    localparam logic [CFG_DW_W-1:0] DW_HDR_INT  = 6'h0F; // bytes 0x3C-0x3F
    localparam logic [CFG_DW_W-1:0] DW_PM_BASE  = 6'h10; // bytes 0x40-0x43
    localparam logic [CFG_DW_W-1:0] DW_SCRATCH  = 6'h16; // bytes 0x58-0x5B
    localparam logic [CFG_DW_W-1:0] DW_PM_CTL   = 6'h20; // byte 0x80 in lane 0
    localparam logic [CFG_DW_W-1:0] DW_SMB_BASE = 6'h24; // bytes 0x90-0x93
    localparam logic [CFG_DW_W-1:0] DW_SMB_CTL  = 6'h34; // byte 0xD2 in lane 2

    localparam logic [31:0] HDR_STS_VAL = 32'h0280_0000;
    localparam logic [31:0] HDR_INT_VAL = 32'h0000_0100;
    localparam logic [7:0]  SMB_CTL_RST = 8'h09;

    // Merge write data into an old dword, lane by lane, under byte enables.
    function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
        logic [31:0] r;
        r = old_v;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/pmcfg_regs.sv
`timescale 1ns/1ps
// Configuration byte storage and read mux.
// Holds only the writable fields; constant and read-only bits are rebuilt
// on read. Flags writes that touch either window's bytes.
module pmcfg_regs
    import pmcfg_pkg::*;
#(
    parameter int          IO_W         = 16,
    parameter int          ALIGN_BITS   = 6,
    parameter logic [15:0] SMB_RST_BASE = 16'hB100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_DW_W-1:0] cfg_dw,
    input  logic [3:0]          cfg_be,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output logic [IO_W-1:0]     pm_base,
    output logic                pm_en,
    output logic [IO_W-1:0]     smb_base,
    output logic                smb_en,
    output logic                pm_touch,
    output logic                smb_touch
);
    localparam int BASE_W = IO_W - ALIGN_BITS;
    localparam int PAD_HI = 32 - IO_W;

    logic [BASE_W-1:0] pm_base_r;
    logic [BASE_W-1:0] smb_base_r;
    logic [7:0]        pm_ctl_r;
    logic [7:0]        smb_ctl_r;
    logic [31:0]       scratch_r;
    logic [31:0]       merged;

    // Read image of the addressed dword, including fixed and read-only bits.
    always_comb begin
        case (cfg_dw)
            DW_HDR_STS:  cfg_rdata = HDR_STS_VAL;
            DW_HDR_INT:  cfg_rdata = HDR_INT_VAL;
            DW_PM_BASE:  cfg_rdata = {{PAD_HI{1'b0}}, pm_base_r, {(ALIGN_BITS-1){1'b0}}, 1'b1};
            DW_SCRATCH:  cfg_rdata = scratch_r;
            DW_PM_CTL:   cfg_rdata = {24'h0, pm_ctl_r};
            DW_SMB_BASE: cfg_rdata = {{PAD_HI{1'b0}}, smb_base_r, {(ALIGN_BITS-1){1'b0}}, 1'b1};
            DW_SMB_CTL:  cfg_rdata = {8'h0, smb_ctl_r, 16'h0};
            default:     cfg_rdata = 32'h0;
        endcase
    end

    // Write data merged over the current read image.
    always_comb merged = be_merge(cfg_rdata, cfg_wdata, cfg_be);

    // Store the writable fields of the addressed dword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_base_r  <= '0;
            smb_base_r <= SMB_RST_BASE[IO_W-1:ALIGN_BITS];
            pm_ctl_r   <= 8'h00;
            smb_ctl_r  <= SMB_CTL_RST;
            scratch_r  <= 32'h0;
        end else if (cfg_wr) begin
            case (cfg_dw)
                DW_PM_BASE:  pm_base_r  <= merged[IO_W-1:ALIGN_BITS];
                DW_SMB_BASE: smb_base_r <= merged[IO_W-1:ALIGN_BITS];
                DW_PM_CTL:   pm_ctl_r   <= merged[7:0];
                DW_SMB_CTL:  smb_ctl_r  <= merged[23:16];
                DW_SCRATCH:  scratch_r  <= merged;
                default: ;
            endcase
        end
    end

    // Flag writes that overlap a window's base dword or cover its enable byte.
    always_comb begin
        pm_touch  = cfg_wr && (((cfg_dw == DW_PM_BASE)  && (|cfg_be)) ||
                               ((cfg_dw == DW_PM_CTL)   && cfg_be[0]));
        smb_touch = cfg_wr && (((cfg_dw == DW_SMB_BASE) && (|cfg_be)) ||
                               ((cfg_dw == DW_SMB_CTL)  && cfg_be[2]));
    end

    assign pm_base  = {pm_base_r,  {ALIGN_BITS{1'b0}}};
    assign smb_base = {smb_base_r, {ALIGN_BITS{1'b0}}};
    assign pm_en    = pm_ctl_r[0];
    assign smb_en   = smb_ctl_r[0];
endmodule

// File: rtl/pmcfg_window.sv
`timescale 1ns/1ps
// One relocatable I/O window: a decode latch plus an aligned compare.
// Assumes the base has zero bits below ALIGN_BITS.
module pmcfg_window #(
    parameter int              IO_W       = 16,
    parameter int              ALIGN_BITS = 6,
    parameter logic [IO_W-1:0] RST_BASE   = '0,
    parameter bit              RST_EN     = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            relatch,
    input  logic [IO_W-1:0] cfg_base,
    input  logic            cfg_en,
    input  logic [IO_W-1:0] io_addr,
    output logic [IO_W-1:0] base_q,
    output logic            en_q,
    output logic            hit
);
    // Copy base and enable from configuration only when asked to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= RST_BASE;
            en_q   <= RST_EN;
        end else if (relatch) begin
            base_q <= cfg_base;
            en_q   <= cfg_en;
        end
    end

    // Compare the aligned upper address bits against the latched base.
    always_comb hit = en_q && (io_addr[IO_W-1:ALIGN_BITS] == base_q[IO_W-1:ALIGN_BITS]);
endmodule

// File: rtl/pmcfg_decoder.sv
`timescale 1ns/1ps
// Top: configuration register file driving two I/O window decoders.
// A write that touches a window is registered, then copied into that
// window's latch on the next edge.
module pmcfg_decoder
    import pmcfg_pkg::*;
#(
    parameter int          IO_W         = 16,
    parameter int          ALIGN_BITS   = 6,
    parameter logic [15:0] SMB_RST_BASE = 16'hB100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_DW_W-1:0] cfg_dw,
    input  logic [3:0]          cfg_be,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic [IO_W-1:0]     io_addr,
    output logic                pm_hit,
    output logic                smb_hit
);
    localparam logic [IO_W-1:0] SMB_RST_ALIGNED =
        SMB_RST_BASE[IO_W-1:0] & ~{{(IO_W-ALIGN_BITS){1'b0}}, {ALIGN_BITS{1'b1}}};

    logic [IO_W-1:0] pm_base_c, smb_base_c, pm_base_q, smb_base_q;
    logic            pm_en_c, smb_en_c, pm_en_q, smb_en_q;
    logic            pm_touch, smb_touch, pm_touch_q, smb_touch_q;

    pmcfg_regs #(.IO_W(IO_W), .ALIGN_BITS(ALIGN_BITS), .SMB_RST_BASE(SMB_RST_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pm_base(pm_base_c), .pm_en(pm_en_c), .smb_base(smb_base_c), .smb_en(smb_en_c),
        .pm_touch(pm_touch), .smb_touch(smb_touch)
    );

    // Delay the touch flags so the latches see the updated configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_touch_q  <= 1'b0;
            smb_touch_q <= 1'b0;
        end else begin
            pm_touch_q  <= pm_touch;
            smb_touch_q <= smb_touch;
        end
    end

    pmcfg_window #(.IO_W(IO_W), .ALIGN_BITS(ALIGN_BITS), .RST_BASE('0), .RST_EN(1'b0)) u_pm_win (
        .clk(clk), .rst_n(rst_n), .relatch(pm_touch_q), .cfg_base(pm_base_c), .cfg_en(pm_en_c),
        .io_addr(io_addr), .base_q(pm_base_q), .en_q(pm_en_q), .hit(pm_hit)
    );

    pmcfg_window #(.IO_W(IO_W), .ALIGN_BITS(ALIGN_BITS), .RST_BASE(SMB_RST_ALIGNED),
                   .RST_EN(SMB_CTL_RST[0])) u_smb_win (
        .clk(clk), .rst_n(rst_n), .relatch(smb_touch_q), .cfg_base(smb_base_c), .cfg_en(smb_en_c),
        .io_addr(io_addr), .base_q(smb_base_q), .en_q(smb_en_q), .hit(smb_hit)
    );
endmodule

// File: rtl/pmcfg_decoder_chk.sv
`timescale 1ns/1ps
// Property checker for pmcfg_decoder, attached by bind.
module pmcfg_decoder_chk #(
    parameter int IO_W       = 16,
    parameter int ALIGN_BITS = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [5:0]      cfg_dw,
    input logic [31:0]     cfg_rdata,
    input logic [IO_W-1:0] io_addr,
    input logic            pm_hit,
    input logic            smb_hit,
    input logic            pm_touch_q,
    input logic            smb_touch_q,
    input logic [IO_W-1:0] pm_base_q,
    input logic [IO_W-1:0] smb_base_q
);
    // R4: read-only bit 0 of both base dwords always reads 1
    p_ro_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw == 6'h10 || cfg_dw == 6'h24) |-> cfg_rdata[0]);

    // R3: status header is constant
    p_hdr_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw == 6'h01) |-> (cfg_rdata == 32'h0280_0000));

    // R5: a power-management hit lies inside the latched window
    p_pm_in_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pm_hit |-> (io_addr[IO_W-1:ALIGN_BITS] == pm_base_q[IO_W-1:ALIGN_BITS]));

    // R6: a bus hit lies inside the latched window
    p_smb_in_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smb_hit |-> (io_addr[IO_W-1:ALIGN_BITS] == smb_base_q[IO_W-1:ALIGN_BITS]));

    // R8: without a touching write, the latched bases hold
    p_pm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_touch_q |=> $stable(pm_base_q));
    p_smb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smb_touch_q |=> $stable(smb_base_q));

    // R7: with no recent touch and a steady address, the hits do not move
    p_pm_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pm_touch_q && !$past(pm_touch_q) && $stable(io_addr)) |-> $stable(pm_hit));
endmodule

bind pmcfg_decoder pmcfg_decoder_chk #(.IO_W(IO_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_dw(cfg_dw), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
    .pm_hit(pm_hit), .smb_hit(smb_hit), .pm_touch_q(pm_touch_q), .smb_touch_q(smb_touch_q),
    .pm_base_q(pm_base_q), .smb_base_q(smb_base_q)
);

// File: tb/pmcfg_decoder_test.sv
`timescale 1ns/1ps
// Self-checking bench: register reads, byte-enable writes and full
// 1024-block sweeps of both windows for several bases.
module pmcfg_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        pm_hit, smb_hit;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pmcfg_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
        .pm_hit(pm_hit), .smb_hit(smb_hit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle; returns at the falling edge after the sampling edge.
    task automatic wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic rd(input string req, input logic [5:0] dw, input logic [31:0] exp);
        cfg_dw = dw;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    // Sweep every 64-byte block; expect a hit only on block base>>6 when enabled.
    task automatic sweep(input string req, input bit smb, input logic [15:0] base, input bit en);
        for (int i = 0; i < 1024; i++) begin
            io_addr = {i[9:0], 6'(i * 7)};
            #1;
            check(req, {31'h0, smb ? smb_hit : pm_hit},
                  {31'h0, en && (i[9:0] == base[15:6])});
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1", 6'h10, 32'h0000_0001);
        rd("R1", 6'h20, 32'h0000_0000);
        sweep("R1", 1'b0, 16'h0000, 1'b0);
        // R2 bus window reset state
        rd("R2", 6'h24, 32'h0000_B101);
        rd("R2", 6'h34, 32'h0009_0000);
        sweep("R2", 1'b1, 16'hB100, 1'b1);
        // R9 scratch reset
        rd("R9", 6'h16, 32'h0);
        // R3 fixed header and ignored writes
        rd("R3", 6'h01, 32'h0280_0000);
        rd("R3", 6'h0F, 32'h0000_0100);
        wr(6'h01, 4'hF, 32'hFFFF_FFFF);
        wr(6'h0F, 4'hF, 32'h0);
        rd("R3", 6'h01, 32'h0280_0000);
        rd("R3", 6'h0F, 32'h0000_0100);

        // R4 writable mask and read-only bit
        wr(6'h10, 4'hF, 32'hFFFF_FFFE);
        rd("R4", 6'h10, 32'h0000_FFC1);
        wr(6'h10, 4'h2, 32'h0000_1200);
        rd("R4", 6'h10, 32'h0000_12C1);
        wr(6'h10, 4'h1, 32'h0000_0000);
        rd("R4", 6'h10, 32'h0000_1201);
        // R9 per-byte scratch
        wr(6'h16, 4'h5, 32'hA1B2_C3D4);
        rd("R9", 6'h16, 32'h00B2_00D4);
        wr(6'h16, 4'hA, 32'hA1B2_C3D4);
        rd("R9", 6'h16, 32'hA1B2_C3D4);

        // R7 latency of enable: write then observe two edges
        io_addr = 16'h1205;
        wr(6'h20, 4'h1, 32'h0000_0001);
        rd("R7", 6'h20, 32'h0000_0001);
        check("R7", {31'h0, pm_hit}, 32'h0);
        @(negedge clk);
        #1;
        check("R7", {31'h0, pm_hit}, 32'h1);
        // R5 sweep at several bases
        sweep("R5", 1'b0, 16'h1200, 1'b1);
        wr(6'h10, 4'h3, 32'h0000_FFC0);
        @(negedge clk);
        sweep("R5", 1'b0, 16'hFFC0, 1'b1);
        wr(6'h10, 4'h3, 32'h0000_0000);
        @(negedge clk);
        sweep("R5", 1'b0, 16'h0000, 1'b1);

        // R8 unrelated writes leave decode alone
        wr(6'h20, 4'hE, 32'h0000_0000);
        wr(6'h16, 4'hF, 32'h0);
        wr(6'h34, 4'hB, 32'h0);
        @(negedge clk);
        rd("R8", 6'h20, 32'h0000_0001);
        rd("R8", 6'h34, 32'h0009_0000);
        sweep("R8", 1'b0, 16'h0000, 1'b1);
        sweep("R8", 1'b1, 16'hB100, 1'b1);

        // R6 bus window relocate and disable
        wr(6'h24, 4'h3, 32'h0000_4440);
        rd("R6", 6'h24, 32'h0000_4441);
        @(negedge clk);
        sweep("R6", 1'b1, 16'h4440, 1'b1);
        wr(6'h34, 4'h4, 32'h0008_0000);
        @(negedge clk);
        rd("R6", 6'h34, 32'h0008_0000);
        sweep("R6", 1'b1, 16'h4440, 1'b0);
        // R5 disable PM window
        wr(6'h20, 4'h1, 32'h0000_0000);
        @(negedge clk);
        sweep("R5", 1'b0, 16'h0000, 1'b0);

        // R1 reset restores defaults
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1", 6'h10, 32'h0000_0001);
        rd("R2", 6'h24, 32'h0000_B101);
        rd("R9", 6'h16, 32'h0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule